// File: doc/BRIEF.md
# SPI Host-Command Response Framer

This block runs one host-command exchange on top of a ring-buffered SPI target. A host clocks bytes in and out of a 64-entry circular buffer without knowing when a reply will be ready, so the framer keeps every byte the host may read next loaded with a meaningful one-byte status code. It collects the request header and checks it. It hands the request to a command processor. When the processor answers, it writes the reply into the ring, wrapped in a frame-start byte and a trailing past-end byte.

The controller follows a fixed sequence. It leaves the off state when enabled, prepares the ring and waits ready. It arms on a chip-select assertion and filters out glitches. It then receives the request, marks itself busy while the processor works and streams the reply. Dropping chip select while the processor is still working leaves the ring in a not-ready state, and the late reply is then discarded. Malformed or slow requests put the ring into a bad-data state until chip select is released. All timeouts count system clock cycles.

Top module: `spi_frm_ctrl`

## Requirements
- R1: Preparing the ring writes 0xF7 to entry 0 and 0xF8 to entries 1 to 63, and the block is then ready to accept a chip-select assertion. Preparation happens when `en` rises, and again after each exchange ends.
- R2: If the first request byte is not 0x03, all 64 ring entries become 0xFB.
- R3: Request bytes 2 (low) and 3 (high) give the total request length in bytes. If that length is below 4 or above 544, all 64 ring entries become 0xFB. A `req_done` pulse always carries a length within 4 to 544.
- R4: Every accepted request byte appears on `rq_valid`/`rq_idx`/`rq_data` in the same cycle. One cycle after the last byte (index length-1), `req_done` pulses for exactly one cycle with `req_len` equal to the length.
- R5: If the request is not complete within CLK_MHZ*8192 cycles of the chip-select assertion, all 64 ring entries become 0xFB.
- R6: When the request completes, all 64 ring entries become 0xFA.
- R7: A reply of N payload bytes is written as 0xEC at (P+2) mod 64, where P is `buf_ptr` when the reply is loaded. The payload follows in order, then 0xED, all with wrap-around. Entries not covered by the reply keep 0xFA.
- R8: The first reply load stops at the end of the following ring half, or earlier if the reply ends first. When the pointer reaches entry 32 (half event) with the load position at 0, or reaches entry 0 (full event) with the load position at 32, the next up-to-32 reply bytes are written into the half just drained. No reply byte beyond the first load is written before that event.
- R9: Releasing chip select while the request is being processed makes all 64 entries 0xFC. A reply arriving after that triggers a ring preparation (R1) instead of a frame.
- R10: If `buf_ptr` does not change within CLK_MHZ*500 cycles of a chip-select assertion, the block prepares the ring again (64 writes with the R1 pattern).
- R11: Releasing chip select while the reply is being sent ends the exchange and prepares the ring (R1).
- R12: While `en` is low, the block writes nothing to the ring and accepts no request bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low holds the controller off |
| cs_assert | input | 1 | One-cycle pulse: chip select became active |
| cs_release | input | 1 | One-cycle pulse: chip select became inactive |
| rx_valid | input | 1 | A request byte has landed in the ring |
| rx_data | input | 8 | The landed request byte |
| buf_ptr | input | 6 | Current ring position of the target |
| evt_half | input | 1 | Pulse: pointer reached entry 32 |
| evt_full | input | 1 | Pulse: pointer wrapped to entry 0 |
| ob_we | output | 1 | Ring write strobe |
| ob_addr | output | 6 | Ring write address |
| ob_data | output | 8 | Ring write data |
| rq_valid | output | 1 | Request byte forwarded to the processor |
| rq_idx | output | 11 | Index of the forwarded byte |
| rq_data | output | 8 | Forwarded byte |
| req_done | output | 1 | Pulse: the whole request is in |
| req_len | output | 10 | Length of the finished request |
| rsp_valid | input | 1 | Pulse: the processor has a reply |
| rsp_len | input | 10 | Reply payload length in bytes |
| rsp_rd_addr | output | 10 | Payload index being fetched |
| rsp_rd_data | input | 8 | Payload byte at `rsp_rd_addr`, same cycle |

## Verification
A wrong controller state shows up at the ring write port within one cycle. It appears as a fill with the wrong status code, a fill that starts from the wrong entry, or a frame byte written where a busy or not-ready code belongs. The check that matters is therefore the full 64-entry ring image a few dozen cycles after each event. It is compared against the code the requirements call for. Reply placement and refill timing show up as the position of 0xEC and 0xED relative to the pointer, and as whether the drained half changes before or after the half event.

// File: rtl/spi_frm_pkg.sv
`timescale 1ns/1ps
package spi_frm_pkg;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_PREP,
        ST_READY,
        ST_ARMED,
        ST_RECV,
        ST_PROC,
        ST_CANCEL,
        ST_SEND,
        ST_BAD
    } frm_state_e;

    typedef enum logic [1:0] {
        JOB_FILL,
        JOB_PREP,
        JOB_RESP,
        JOB_REFILL
    } job_kind_e;

    typedef struct packed {
        job_kind_e  kind;
        logic [7:0] code;
    } job_t;

    function automatic job_t make_job(job_kind_e k, logic [7:0] c);
        job_t j;
        j.kind = k;
        j.code = c;
        return j;
    endfunction

endpackage

// File: rtl/frm_timeout.sv
`timescale 1ns/1ps
module frm_timeout #(
    parameter int LIMIT = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(LIMIT - 1);
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = run && !start && (cnt == '0);
endmodule

// File: rtl/frm_obuf_writer.sv
`timescale 1ns/1ps
module frm_obuf_writer
    import spi_frm_pkg::*;
#(
    parameter int         DEPTH      = 64,
    parameter int         LEN_W      = 10,
    parameter logic [7:0] LEGACY_RDY = 8'hF7,
    parameter logic [7:0] FRAME_CODE = 8'hEC,
    parameter logic [7:0] TAIL_CODE  = 8'hED
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        abort,
    input  logic                        start,
    input  job_t                        job,
    input  logic [$clog2(DEPTH)-1:0]    start_addr,
    input  logic [$clog2(DEPTH):0]      start_cnt,
    input  logic [LEN_W:0]              total,
    input  logic [7:0]                  rsp_rd_data,
    output logic [LEN_W-1:0]            rsp_rd_addr,
    output logic                        busy,
    output logic [$clog2(DEPTH)-1:0]    wr_pos,
    output logic [LEN_W:0]              sent,
    output logic                        ob_we,
    output logic [$clog2(DEPTH)-1:0]    ob_addr,
    output logic [7:0]                  ob_data
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam int TW = LEN_W + 1;

    job_t          cur;
    logic [AW-1:0] addr;
    logic [CW-1:0] left;
    logic [TW-1:0] idx;
    logic [TW-1:0] idx_m1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cur  <= make_job(JOB_FILL, 8'h00);
            addr <= '0;
            left <= '0;
            idx  <= '0;
        end else if (abort) begin
            busy <= 1'b0;
        end else if (start) begin
            busy <= (start_cnt != '0);
            cur  <= job;
            left <= start_cnt;
            if (job.kind != JOB_REFILL) addr <= start_addr;
            if (job.kind == JOB_RESP)   idx  <= '0;
        end else if (busy) begin
            addr <= addr + 1'b1;
            left <= left - 1'b1;
            idx  <= idx + 1'b1;
            if (left == CW'(1)) busy <= 1'b0;
        end
    end

    assign idx_m1      = idx - 1'b1;
    assign rsp_rd_addr = idx_m1[LEN_W-1:0];
    assign wr_pos      = addr;
    assign sent        = idx;
    assign ob_we       = busy;
    assign ob_addr     = addr;

    always_comb begin
        unique case (cur.kind)
            JOB_PREP: ob_data = (addr == '0) ? LEGACY_RDY : cur.code;
            JOB_FILL: ob_data = cur.code;
            default: begin
                if (idx == '0)                     ob_data = FRAME_CODE;
                else if (idx == total - 1'b1)      ob_data = TAIL_CODE;
                else                               ob_data = rsp_rd_data;
            end
        endcase
    end
endmodule

// File: rtl/spi_frm_ctrl.sv
`timescale 1ns/1ps
module spi_frm_ctrl
    import spi_frm_pkg::*;
#(
    parameter int         CLK_MHZ       = 100,
    parameter int         RX_TIMEOUT_US = 8192,
    parameter int         GLITCH_US     = 500,
    parameter int         DEPTH         = 64,
    parameter int         PREAMBLE      = 2,
    parameter int         MAX_REQ       = 544,
    parameter int         HDR_LEN       = 4,
    parameter logic [7:0] VERSION       = 8'h03,
    parameter logic [7:0] LEGACY_RDY    = 8'hF7,
    parameter logic [7:0] CODE_RECV     = 8'hF8,
    parameter logic [7:0] CODE_BUSY     = 8'hFA,
    parameter logic [7:0] CODE_BAD      = 8'hFB,
    parameter logic [7:0] CODE_NRDY     = 8'hFC,
    parameter logic [7:0] FRAME_CODE    = 8'hEC,
    parameter logic [7:0] TAIL_CODE     = 8'hED
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         en,
    input  logic                         cs_assert,
    input  logic                         cs_release,
    input  logic                         rx_valid,
    input  logic [7:0]                   rx_data,
    input  logic [$clog2(DEPTH)-1:0]     buf_ptr,
    input  logic                         evt_half,
    input  logic                         evt_full,
    output logic                         ob_we,
    output logic [$clog2(DEPTH)-1:0]     ob_addr,
    output logic [7:0]                   ob_data,
    output logic                         rq_valid,
    output logic [$clog2(MAX_REQ+1):0]   rq_idx,
    output logic [7:0]                   rq_data,
    output logic                         req_done,
    output logic [$clog2(MAX_REQ+1)-1:0] req_len,
    input  logic                         rsp_valid,
    input  logic [$clog2(MAX_REQ+1)-1:0] rsp_len,
    output logic [$clog2(MAX_REQ+1)-1:0] rsp_rd_addr,
    input  logic [7:0]                   rsp_rd_data
);
    localparam int AW       = $clog2(DEPTH);
    localparam int CW       = AW + 1;
    localparam int HALF     = DEPTH / 2;
    localparam int LEN_W    = $clog2(MAX_REQ + 1);
    localparam int TW       = LEN_W + 1;
    localparam int RX_LIMIT = CLK_MHZ * RX_TIMEOUT_US;
    localparam int GL_LIMIT = CLK_MHZ * GLITCH_US;
    localparam int LEN_LO   = 2;
    localparam int LEN_HI   = 3;

    frm_state_e      st, st_n;
    logic [AW-1:0]   pre_ptr;
    logic [TW-1:0]   rx_cnt;
    logic [7:0]      lo_q;
    logic [LEN_W-1:0] len_q;
    logic [TW-1:0]   rsp_total_q;
    logic            rsp_pend, lo_pend, hi_pend;
    logic            req_done_q;
    logic [LEN_W-1:0] req_len_q;

    // engine side
    logic            eng_busy, job_go;
    job_t            job;
    logic [AW-1:0]   job_addr, wr_pos;
    logic [CW-1:0]   job_cnt;
    logic [TW-1:0]   eng_sent;

    // timers
    logic arm_go, gl_exp, rx_exp;

    // request byte decode
    logic [15:0]      hdr_len;
    logic [LEN_W-1:0] need_len;
    logic             rx_take, byte_bad, byte_last;

    // comb actions
    logic do_prep, do_bad, do_done, do_cancel, do_resp, do_refill;
    logic [AW-1:0]   fill_base;
    logic [TW-1:0]   tot_now, first_room, first_cnt, rem, refill_cnt;

    assign arm_go   = en && (st == ST_READY) && cs_assert;
    assign rx_take  = en && rx_valid && (st == ST_ARMED || st == ST_RECV);
    assign hdr_len  = {rx_data, lo_q};
    assign need_len = (rx_cnt == TW'(LEN_HI)) ? hdr_len[LEN_W-1:0] : len_q;
    assign byte_bad = rx_take &&
                      ((rx_cnt == '0 && rx_data != VERSION) ||
                       (rx_cnt == TW'(LEN_HI) &&
                        (hdr_len < 16'(HDR_LEN) || hdr_len > 16'(MAX_REQ))));
    assign byte_last = rx_take && !byte_bad && (rx_cnt >= TW'(LEN_HI)) &&
                       ((rx_cnt + 1'b1) == TW'(need_len));

    assign fill_base  = buf_ptr + AW'(PREAMBLE);
    assign tot_now    = rsp_pend ? rsp_total_q : (TW'(rsp_len) + TW'(2));
    assign first_room = TW'(DEPTH) - TW'(fill_base[AW-2:0]);
    assign first_cnt  = (tot_now < first_room) ? tot_now : first_room;
    assign rem        = rsp_total_q - eng_sent;
    assign refill_cnt = (rem < TW'(HALF)) ? rem : TW'(HALF);

    frm_timeout #(.LIMIT(GL_LIMIT)) u_glitch_tmr (
        .clk(clk), .rst(rst), .start(arm_go),
        .run(st == ST_ARMED), .expired(gl_exp)
    );

    frm_timeout #(.LIMIT(RX_LIMIT)) u_rx_tmr (
        .clk(clk), .rst(rst), .start(arm_go),
        .run(st == ST_ARMED || st == ST_RECV), .expired(rx_exp)
    );

    // state decision
    always_comb begin
        st_n      = st;
        do_prep   = 1'b0;
        do_bad    = 1'b0;
        do_done   = 1'b0;
        do_cancel = 1'b0;
        do_resp   = 1'b0;
        do_refill = 1'b0;
        if (!en) begin
            st_n = ST_OFF;
        end else begin
            unique case (st)
                ST_OFF:  do_prep = 1'b1;
                ST_PREP: if (!eng_busy) st_n = ST_READY;
                ST_READY: begin
                    if (cs_assert)       st_n = ST_ARMED;
                    else if (cs_release) do_prep = 1'b1;
                end
                ST_ARMED, ST_RECV: begin
                    if (cs_release)     do_prep = 1'b1;
                    else if (byte_bad)  do_bad  = 1'b1;
                    else if (byte_last) do_done = 1'b1;
                    else if (rx_exp)    do_bad  = 1'b1;
                    else if (st == ST_ARMED) begin
                        if (buf_ptr != pre_ptr) st_n = ST_RECV;
                        else if (gl_exp)        do_prep = 1'b1;
                    end
                end
                ST_PROC: begin
                    if (cs_release) do_cancel = 1'b1;
                    else if ((rsp_valid || rsp_pend) && !eng_busy) do_resp = 1'b1;
                end
                ST_CANCEL: if (rsp_valid) do_prep = 1'b1;
                ST_SEND: begin
                    if (cs_release) do_prep = 1'b1;
                    else if (!eng_busy && rem != '0 &&
                             ((lo_pend && wr_pos == '0) ||
                              (hi_pend && wr_pos == AW'(HALF))))
                        do_refill = 1'b1;
                end
                ST_BAD: if (cs_release) do_prep = 1'b1;
                default: st_n = ST_OFF;
            endcase
            if (do_prep)   st_n = ST_PREP;
            if (do_bad)    st_n = ST_BAD;
            if (do_done)   st_n = ST_PROC;
            if (do_cancel) st_n = ST_CANCEL;
            if (do_resp)   st_n = ST_SEND;
        end
    end

    // engine job selection
    always_comb begin
        job_go   = 1'b1;
        job      = make_job(JOB_FILL, CODE_BUSY);
        job_addr = fill_base;
        job_cnt  = CW'(DEPTH);
        if (do_prep) begin
            job      = make_job(JOB_PREP, CODE_RECV);
            job_addr = '0;
        end else if (do_bad) begin
            job = make_job(JOB_FILL, CODE_BAD);
        end else if (do_done) begin
            job = make_job(JOB_FILL, CODE_BUSY);
        end else if (do_cancel) begin
            job = make_job(JOB_FILL, CODE_NRDY);
        end else if (do_resp) begin
            job     = make_job(JOB_RESP, 8'h00);
            job_cnt = CW'(first_cnt);
        end else if (do_refill) begin
            job     = make_job(JOB_REFILL, 8'h00);
            job_cnt = CW'(refill_cnt);
        end else begin
            job_go = 1'b0;
        end
    end

    frm_obuf_writer #(
        .DEPTH(DEPTH), .LEN_W(LEN_W), .LEGACY_RDY(LEGACY_RDY),
        .FRAME_CODE(FRAME_CODE), .TAIL_CODE(TAIL_CODE)
    ) u_writer (
        .clk(clk), .rst(rst), .abort(!en), .start(job_go), .job(job),
        .start_addr(job_addr), .start_cnt(job_cnt), .total(rsp_total_q),
        .rsp_rd_data(rsp_rd_data), .rsp_rd_addr(rsp_rd_addr),
        .busy(eng_busy), .wr_pos(wr_pos), .sent(eng_sent),
        .ob_we(ob_we), .ob_addr(ob_addr), .ob_data(ob_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_OFF;
            pre_ptr     <= '0;
            rx_cnt      <= '0;
            lo_q        <= '0;
            len_q       <= '0;
            rsp_total_q <= '0;
            rsp_pend    <= 1'b0;
            lo_pend     <= 1'b0;
            hi_pend     <= 1'b0;
            req_done_q  <= 1'b0;
            req_len_q   <= '0;
        end else begin
            st         <= st_n;
            req_done_q <= do_done;
            if (do_done) req_len_q <= need_len;
            if (st == ST_PREP && st_n == ST_READY) pre_ptr <= buf_ptr;
            if (arm_go) begin
                rx_cnt <= '0;
            end else if (rx_take) begin
                rx_cnt <= rx_cnt + 1'b1;
                if (rx_cnt == TW'(LEN_LO)) lo_q  <= rx_data;
                if (rx_cnt == TW'(LEN_HI)) len_q <= hdr_len[LEN_W-1:0];
            end
            if (en && st == ST_PROC && rsp_valid)
                rsp_total_q <= TW'(rsp_len) + TW'(2);
            rsp_pend <= (st_n == ST_PROC) && !do_resp &&
                        (rsp_pend || (st == ST_PROC && rsp_valid));
            lo_pend  <= (st_n == ST_SEND) && (evt_half || (lo_pend && eng_busy));
            hi_pend  <= (st_n == ST_SEND) && (evt_full || (hi_pend && eng_busy));
        end
    end

    assign rq_valid = rx_take;
    assign rq_idx   = rx_cnt;
    assign rq_data  = rx_data;
    assign req_done = req_done_q;
    assign req_len  = req_len_q;
endmodule

// File: rtl/spi_frm_ctrl_chk.sv
`timescale 1ns/1ps
module spi_frm_ctrl_chk
    import spi_frm_pkg::*;
#(
    parameter int         MAX_REQ    = 544,
    parameter int         HDR_LEN    = 4,
    parameter int         LEN_W      = 10,
    parameter logic [7:0] FRAME_CODE = 8'hEC
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             cs_release,
    input logic             ob_we,
    input logic [7:0]       ob_data,
    input logic             req_done,
    input logic [LEN_W-1:0] req_len,
    input frm_state_e       st
);
    // R7: a frame-start byte reaches the ring only while sending
    p_frame_in_send_r7: assert property (@(posedge clk) disable iff (rst)
        (ob_we && ob_data == FRAME_CODE) |-> st == ST_SEND);

    // R3: a finished request always has a legal length
    p_len_range_r3: assert property (@(posedge clk) disable iff (rst)
        req_done |-> (req_len >= LEN_W'(HDR_LEN) && req_len <= LEN_W'(MAX_REQ)));

    // R4: completion is a single-cycle pulse
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        req_done |=> !req_done);

    // R9: release during processing cancels
    p_cancel_r9: assert property (@(posedge clk) disable iff (rst)
        (en && st == ST_PROC && cs_release) |=> st == ST_CANCEL);

    // R12: disabled block leaves the ring alone
    p_off_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !en |=> !ob_we);
endmodule

bind spi_frm_ctrl spi_frm_ctrl_chk #(
    .MAX_REQ(MAX_REQ), .HDR_LEN(HDR_LEN), .LEN_W(LEN_W), .FRAME_CODE(FRAME_CODE)
) u_chk (
    .clk(clk), .rst(rst), .en(en), .cs_release(cs_release), .ob_we(ob_we),
    .ob_data(ob_data), .req_done(req_done), .req_len(req_len), .st(st)
);

// File: tb/spi_frm_ctrl_test.sv
`timescale 1ns/1ps
module spi_frm_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       cs_assert = 1'b0, cs_release = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic [5:0] buf_ptr = 6'd0;
    logic       evt_half = 1'b0, evt_full = 1'b0;
    logic       ob_we;
    logic [5:0] ob_addr;
    logic [7:0] ob_data;
    logic       rq_valid;
    logic [10:0] rq_idx;
    logic [7:0] rq_data;
    logic       req_done;
    logic [9:0] req_len;
    logic       rsp_valid = 1'b0;
    logic [9:0] rsp_len = 10'd0;
    logic [9:0] rsp_rd_addr;
    logic [7:0] rsp_rd_data;

    int checks = 0, fails = 0;
    int wr_cnt = 0, done_cnt = 0, rq_cnt = 0;
    int last_len = 0, last_idx = 0, last_rq = 0;
    logic [7:0] ring [64];
    bit finished = 0;

    always #5 clk = ~clk;

    function automatic logic [7:0] pat(int i);
        return 8'(i) ^ 8'h5A;
    endfunction
    assign rsp_rd_data = pat(int'(rsp_rd_addr));

    spi_frm_ctrl #(.CLK_MHZ(1)) uut (
        .clk(clk), .rst(rst), .en(en), .cs_assert(cs_assert),
        .cs_release(cs_release), .rx_valid(rx_valid), .rx_data(rx_data),
        .buf_ptr(buf_ptr), .evt_half(evt_half), .evt_full(evt_full),
        .ob_we(ob_we), .ob_addr(ob_addr), .ob_data(ob_data),
        .rq_valid(rq_valid), .rq_idx(rq_idx), .rq_data(rq_data),
        .req_done(req_done), .req_len(req_len), .rsp_valid(rsp_valid),
        .rsp_len(rsp_len), .rsp_rd_addr(rsp_rd_addr), .rsp_rd_data(rsp_rd_data)
    );

    always @(posedge clk) begin
        if (ob_we) begin ring[ob_addr] <= ob_data; wr_cnt <= wr_cnt + 1; end
        if (req_done) begin done_cnt <= done_cnt + 1; last_len <= int'(req_len); end
        if (rq_valid) begin rq_cnt <= rq_cnt + 1; last_idx <= int'(rq_idx); last_rq <= int'(rq_data); end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic check_fill(logic [7:0] code, string req);
        int bad = 0;
        for (int i = 0; i < 64; i++) if (ring[i] !== code) bad++;
        check(bad == 0, req, bad, 0);
    endtask

    task automatic check_ready(string req);
        int bad = 0;
        if (ring[0] !== 8'hF7) bad++;
        for (int i = 1; i < 64; i++) if (ring[i] !== 8'hF8) bad++;
        check(bad == 0, req, bad, 0);
    endtask

    task automatic cs_on();
        @(negedge clk); cs_assert = 1'b1;
        @(negedge clk); cs_assert = 1'b0;
    endtask

    task automatic cs_off();
        @(negedge clk); cs_release = 1'b1; buf_ptr = 6'd0;
        @(negedge clk); cs_release = 1'b0;
    endtask

    task automatic send(logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b; buf_ptr = buf_ptr + 6'd1;
        evt_half = (buf_ptr == 6'd32); evt_full = (buf_ptr == 6'd0);
        @(negedge clk);
        rx_valid = 1'b0; evt_half = 1'b0; evt_full = 1'b0;
    endtask

    task automatic reply(int n);
        @(negedge clk); rsp_valid = 1'b1; rsp_len = 10'(n);
        @(negedge clk); rsp_valid = 1'b0;
    endtask

    task automatic t_start();
        int w0;
        tick(3); rst = 1'b0; tick(20);
        check(wr_cnt == 0, "R12 writes while off", wr_cnt, 0);
        en = 1'b1; tick(80);
        check_ready("R1 prepared ring");
        w0 = wr_cnt;
        check(w0 == 64, "R1 prepare write count", w0, 64);
    endtask

    task automatic t_bad_version();
        cs_on(); send(8'h02); tick(80);
        check_fill(8'hFB, "R2 wrong version fill");
        cs_off(); tick(80);
        check_ready("R1 ready after bad exchange");
    endtask

    task automatic t_bad_length();
        cs_on(); send(8'h03); send(8'h01); send(8'h30); send(8'h02); tick(80);
        check_fill(8'hFB, "R3 length 560 rejected");
        cs_off(); tick(80);
        cs_on(); send(8'h03); send(8'h01); send(8'h02); send(8'h00); tick(80);
        check_fill(8'hFB, "R3 length 2 rejected");
        check(done_cnt == 0, "R3 no completion on bad length", done_cnt, 0);
        cs_off(); tick(80);
    endtask

    task automatic t_short_reply();
        cs_on(); send(8'h03); send(8'h11); send(8'h06); send(8'h00);
        send(8'hAA); send(8'hBB); tick(2);
        check(done_cnt == 1, "R4 one completion", done_cnt, 1);
        check(last_len == 6, "R4 completion length", last_len, 6);
        check(last_idx == 5 && last_rq == 8'hBB, "R4 last forwarded byte", last_rq, 8'hBB);
        tick(80);
        check_fill(8'hFA, "R6 busy fill");
        reply(5); tick(20);
        check(ring[8] == 8'hEC, "R7 frame at ptr+2", int'(ring[8]), 8'hEC);
        for (int i = 0; i < 5; i++)
            check(ring[9+i] == pat(i), "R7 payload order", int'(ring[9+i]), int'(pat(i)));
        check(ring[14] == 8'hED, "R7 past-end byte", int'(ring[14]), 8'hED);
        check(ring[15] == 8'hFA && ring[7] == 8'hFA, "R7 neighbours untouched", int'(ring[15]), 8'hFA);
        cs_off(); tick(80);
        check_ready("R11 release while sending");
    endtask

    task automatic t_long_reply();
        cs_on(); send(8'h03); send(8'h22); send(8'h04); send(8'h00); tick(80);
        reply(60); tick(80);
        check(ring[6] == 8'hEC, "R7 frame at ptr+2 long", int'(ring[6]), 8'hEC);
        check(ring[63] == pat(56), "R8 first load reaches top", int'(ring[63]), int'(pat(56)));
        check(ring[0] == 8'hFA, "R8 no refill before event", int'(ring[0]), 8'hFA);
        for (int i = 0; i < 28; i++) send(8'h00);
        tick(10);
        for (int i = 0; i < 3; i++)
            check(ring[i] == pat(57+i), "R8 refill payload", int'(ring[i]), int'(pat(57+i)));
        check(ring[3] == 8'hED, "R8 refill past-end", int'(ring[3]), 8'hED);
        check(ring[4] == 8'hFA, "R8 refill stops at end", int'(ring[4]), 8'hFA);
        cs_off(); tick(80);
        check_ready("R11 ready after long reply");
    endtask

    task automatic t_cancel();
        cs_on(); send(8'h03); send(8'h33); send(8'h04); send(8'h00); tick(80);
        cs_off(); tick(80);
        check_fill(8'hFC, "R9 not-ready fill");
        reply(4); tick(80);
        check_ready("R9 late reply prepares ring");
    endtask

    task automatic t_timeout();
        cs_on(); send(8'h03); send(8'h01); tick(8300);
        check_fill(8'hFB, "R5 receive timeout");
        cs_off(); tick(80);
    endtask

    task automatic t_glitch();
        int w0;
        w0 = wr_cnt;
        cs_on(); tick(400);
        check(wr_cnt == w0, "R10 no action before limit", wr_cnt - w0, 0);
        tick(200);
        check(wr_cnt - w0 == 64, "R10 glitch prepares ring", wr_cnt - w0, 64);
        check_ready("R10 ring pattern after glitch");
        cs_off(); tick(80);
    endtask

    task automatic t_disabled();
        int w0, d0, q0;
        en = 1'b0; tick(5);
        w0 = wr_cnt; d0 = done_cnt; q0 = rq_cnt;
        cs_on(); send(8'h03); send(8'h01); send(8'h04); send(8'h00); tick(80);
        check(wr_cnt == w0, "R12 no writes while off", wr_cnt - w0, 0);
        check(rq_cnt == q0 && done_cnt == d0, "R12 no bytes accepted", rq_cnt - q0, 0);
        buf_ptr = 6'd0;
        en = 1'b1; tick(80);
        check_ready("R1 prepare on re-enable");
    endtask

    initial begin
        t_start();
        t_bad_version();
        t_bad_length();
        t_short_reply();
        t_long_reply();
        t_cancel();
        t_timeout();
        t_glitch();
        t_disabled();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule